// File: doc/BRIEF.md
# Parallel Second-Order Section IIR Filter

This block is a recursive filter of order `ORDER` built as a bank of independent second-order sections. Every section sees the same input sample. Their outputs are added to a scaled copy of the input, which is the direct feed-through term, and the total is requantized to the output width. The transfer function is C + Σ H_k(z). Each H_k(z) has the numerator a0_k + a1_k·z⁻¹ and the denominator 1 + b1_k·z⁻¹ + b2_k·z⁻². When the order is odd, the last section degenerates to first order.

Samples enter on a valid/ready stream and leave on a valid/ready stream. The input is an integer sample. Coefficients are signed values with `FRAC` fractional bits and arrive on plain input pins. An accepted sample advances every section once, and a cycle with no accepted sample leaves the filter state alone. When the consumer holds `out_ready` low while a result is waiting, the result stays fixed and the block stops taking new samples. The sections are independent, so their outputs are added in one pipelined tree.

Top module: `pfb_parallel_iir`

## Requirements
- R1: While `srst` is high at a clock edge, every section state word, the feed-through register and both pipeline valid flags are cleared. In the cycle after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For each accepted sample x, the result before requantization equals C·x plus the sum of all section outputs y_k = a0_k·w_k + a1_k·w1_k. This value is scaled by 2^FRAC.
- R3: Each section forms its new state as w_k = floor((x·2^FRAC − b1_k·w1_k − b2_k·w2_k) / 2^FRAC). The result is clamped to the signed `STATE_W` range. On the same accepted sample the section then shifts w2_k ← w1_k and w1_k ← w_k.
- R4: The bank has (ORDER+1)/2 sections. Section k takes its coefficient from bits [k·COEF_W +: COEF_W] of each packed coefficient port. When ORDER is odd, the last section is first order, and its `coef_num1` and `coef_den2` fields have no effect on the output.
- R5: If a sample is accepted at clock edge E and `out_valid` is low at E+1, its result is presented with `out_valid` high after edge E+1. It is not yet valid after edge E.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_sample` and `out_valid` hold their values into the next cycle.
- R7: A cycle in which `in_valid` is 0 does not change any section state. The output sequence depends only on the accepted samples.
- R8: With `ROUND_HALF`=1, the sum has 2^(FRAC−1) added before the arithmetic shift right by `FRAC`. With `ROUND_HALF`=0, the sum is floored.
- R9: With `SATURATE`=1, the shifted sum is clamped to the signed `OUT_W` range. With `SATURATE`=0, its low `OUT_W` bits are kept (two's-complement wrap).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | IN_W | Signed input sample |
| out_valid | output | 1 | Result waiting on `out_sample` |
| out_ready | input | 1 | Consumer takes the result |
| out_sample | output | OUT_W | Signed requantized result |
| coef_num0 | input | NSEC·COEF_W | Packed a0 per section |
| coef_num1 | input | NSEC·COEF_W | Packed a1 per section |
| coef_den1 | input | NSEC·COEF_W | Packed b1 per section |
| coef_den2 | input | NSEC·COEF_W | Packed b2 per section |
| coef_direct | input | COEF_W | Feed-through gain C |

## Verification
The bench builds the block with ORDER=5, 8-bit input, 8-bit coefficients with 6 fractional bits, a 12-bit state and an 8-bit output. This gives three sections, the last one first order, and it carries deliberately nonzero a1 and b2 values that the result must ignore. One instance rounds and saturates, and a second instance floors and wraps. Both receive the same stream.

With only 256 input codes, every one of them can be ramped through each of five coefficient sets, together with impulses of both signs at full scale. One set drives the state and the output into clamping. Some sets offer input every cycle. Others gate `in_valid` and `out_ready` irregularly, which exercises bubbles and back-pressure.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  // larger of two elaboration-time integers
  function automatic int pick_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // largest positive value of a signed word of width w
  function automatic longint signed_top(input int w);
    return (longint'(1) <<< (w - 1)) - 1;
  endfunction

endpackage

// File: rtl/pfb_section.sv
module pfb_section
  import pfb_pkg::*;
#(
  parameter int XW = 8,
  parameter int CW = 8,
  parameter int SW = 12,
  parameter int CF = 6,
  parameter bit FIRST_ORDER = 1'b0,
  parameter int YW = CW + SW + 2
) (
  input  logic                 clk,
  input  logic                 srst,
  input  logic                 load,
  input  logic signed [XW-1:0] x,
  input  logic signed [CW-1:0] a0,
  input  logic signed [CW-1:0] a1,
  input  logic signed [CW-1:0] b1,
  input  logic signed [CW-1:0] b2,
  output logic signed [YW-1:0] y_q
);
  localparam int     AW   = pick_max(XW + CF, CW + SW) + 3;
  localparam longint SMAX = signed_top(SW);
  localparam longint SMIN = -SMAX - 1;

  logic signed [SW-1:0] w1, w2, w_new;
  logic signed [AW-1:0] fb1, fb2, acc, wq;
  logic signed [YW-1:0] ff0, ff1;
  logic signed [CW-1:0] a1_eff, b2_eff;

  // a first-order section has no z^-1 numerator term and no second pole
  assign a1_eff = FIRST_ORDER ? '0 : a1;
  assign b2_eff = FIRST_ORDER ? '0 : b2;

  always_comb begin
    fb1 = AW'(b1) * AW'(w1);
    fb2 = AW'(b2_eff) * AW'(w2);
    acc = (AW'(x) <<< CF) - fb1 - fb2;
    wq  = acc >>> CF;
    if (wq > AW'(SMAX))      w_new = SW'(SMAX);
    else if (wq < AW'(SMIN)) w_new = SW'(SMIN);
    else                     w_new = SW'(wq);
    ff0 = YW'(a0) * YW'(w_new);
    ff1 = YW'(a1_eff) * YW'(w1);
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      w1  <= '0;
      w2  <= '0;
      y_q <= '0;
    end else if (load) begin
      w2  <= w1;
      w1  <= w_new;
      y_q <= ff0 + ff1;
    end
  end
endmodule

// File: rtl/pfb_adder_tree.sv
module pfb_adder_tree #(
  parameter int NLEAF = 4,
  parameter int W     = 24
) (
  input  logic signed [W-1:0] leaf [NLEAF],
  output logic signed [W-1:0] total
);
  localparam int P2 = 1 << $clog2(NLEAF);

  logic signed [W-1:0] node [1:2*P2-1];

  generate
    for (genvar i = 0; i < P2; i++) begin : g_leaf
      if (i < NLEAF) begin : g_used
        assign node[P2+i] = leaf[i];
      end else begin : g_pad
        assign node[P2+i] = '0;
      end
    end
    for (genvar j = 1; j < P2; j++) begin : g_add
      assign node[j] = node[2*j] + node[2*j+1];
    end
  endgenerate

  assign total = node[1];
endmodule

// File: rtl/pfb_requant.sv
module pfb_requant
  import pfb_pkg::*;
#(
  parameter int IW    = 25,
  parameter int OW    = 8,
  parameter int CF    = 6,
  parameter bit ROUND = 1'b1,
  parameter bit SAT   = 1'b1
) (
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] dout
);
  localparam int     BW   = IW + 1;
  localparam longint HALF = ROUND ? (longint'(1) <<< (CF - 1)) : longint'(0);
  localparam longint OMAX = signed_top(OW);
  localparam longint OMIN = -OMAX - 1;

  logic signed [BW-1:0] biased, shifted;

  always_comb begin
    biased  = BW'(din) + BW'(HALF);
    shifted = biased >>> CF;
    if (SAT && (shifted > BW'(OMAX)))      dout = OW'(OMAX);
    else if (SAT && (shifted < BW'(OMIN))) dout = OW'(OMIN);
    else                                   dout = shifted[OW-1:0];
  end
endmodule

// File: rtl/pfb_parallel_iir.sv
module pfb_parallel_iir
  import pfb_pkg::*;
#(
  parameter int ORDER      = 5,
  parameter int IN_W       = 8,
  parameter int COEF_W     = 8,
  parameter int STATE_W    = 12,
  parameter int FRAC       = 6,
  parameter int OUT_W      = 8,
  parameter bit ROUND_HALF = 1'b1,
  parameter bit SATURATE   = 1'b1,
  localparam int NSEC      = (ORDER + 1) / 2
) (
  input  logic                     clk,
  input  logic                     srst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [IN_W-1:0]   in_sample,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [OUT_W-1:0]  out_sample,
  input  logic [NSEC*COEF_W-1:0]   coef_num0,
  input  logic [NSEC*COEF_W-1:0]   coef_num1,
  input  logic [NSEC*COEF_W-1:0]   coef_den1,
  input  logic [NSEC*COEF_W-1:0]   coef_den2,
  input  logic signed [COEF_W-1:0] coef_direct
);
  localparam bit LAST_FIRST = (ORDER % 2) == 1;
  localparam int YW  = COEF_W + STATE_W + 2;
  localparam int CXW = COEF_W + IN_W;
  localparam int TW  = pick_max(YW, CXW) + $clog2(NSEC + 1) + 1;

  logic v1, v2, adv, accept;
  logic signed [YW-1:0]  sec_y [NSEC];
  logic signed [CXW-1:0] cx_q;
  logic signed [TW-1:0]  leaf [NSEC+1];
  logic signed [TW-1:0]  tree_sum, sum_q;

  assign adv      = !v2 || out_ready;
  assign in_ready = adv;
  assign accept   = in_valid && adv;

  generate
    for (genvar k = 0; k < NSEC; k++) begin : g_sec
      localparam bit FO = LAST_FIRST && (k == NSEC - 1);
      pfb_section #(
        .XW(IN_W), .CW(COEF_W), .SW(STATE_W), .CF(FRAC),
        .FIRST_ORDER(FO), .YW(YW)
      ) u_sec (
        .clk (clk),
        .srst(srst),
        .load(accept),
        .x   (in_sample),
        .a0  (coef_num0[k*COEF_W +: COEF_W]),
        .a1  (coef_num1[k*COEF_W +: COEF_W]),
        .b1  (coef_den1[k*COEF_W +: COEF_W]),
        .b2  (coef_den2[k*COEF_W +: COEF_W]),
        .y_q (sec_y[k])
      );
      assign leaf[k] = TW'(sec_y[k]);
    end
  endgenerate

  assign leaf[NSEC] = TW'(cx_q);

  pfb_adder_tree #(.NLEAF(NSEC + 1), .W(TW)) u_tree (
    .leaf (leaf),
    .total(tree_sum)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      v1    <= 1'b0;
      v2    <= 1'b0;
      cx_q  <= '0;
      sum_q <= '0;
    end else begin
      if (accept) cx_q <= CXW'(coef_direct) * CXW'(in_sample);
      if (adv) begin
        v1    <= accept;
        v2    <= v1;
        sum_q <= tree_sum;
      end
    end
  end

  assign out_valid = v2;

  pfb_requant #(
    .IW(TW), .OW(OUT_W), .CF(FRAC), .ROUND(ROUND_HALF), .SAT(SATURATE)
  ) u_rq (
    .din (sum_q),
    .dout(out_sample)
  );
endmodule

// File: rtl/pfb_parallel_iir_chk.sv
module pfb_parallel_iir_chk #(
  parameter int OW = 8
) (
  input logic          clk,
  input logic          srst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_sample
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (srst)
    out_valid && !out_ready |=> out_valid && $stable(out_sample)); // R6

  AST_STALL_BLOCKS_INTAKE: assert property (@(posedge clk) disable iff (srst)
    out_valid && !out_ready |-> !in_ready); // R6

  AST_TWO_STAGE_LATENCY: assert property (@(posedge clk) disable iff (srst)
    (in_valid && in_ready) ##1 (out_ready || !out_valid) |=> out_valid); // R5

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (srst)
    $past(srst) |-> !out_valid && in_ready); // R1
endmodule

bind pfb_parallel_iir pfb_parallel_iir_chk #(.OW(OUT_W)) u_chk (
  .clk       (clk),
  .srst      (srst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sample(out_sample)
);

// File: tb/tb_pfb_parallel_iir.sv
`timescale 1ns/1ps
module tb_pfb_parallel_iir;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic signed [7:0] in_sample = '0;
  logic [NS*8-1:0] c_n0 = '0, c_n1 = '0, c_d1 = '0, c_d2 = '0;
  logic signed [7:0] c_dir = '0;
  logic in_ready, out_valid, in_ready_t, out_valid_t;
  logic signed [7:0] out_sample, out_sample_t;

  always #10 clk = ~clk;

  pfb_parallel_iir #(.ORDER(5), .IN_W(8), .COEF_W(8), .STATE_W(12), .FRAC(6),
    .OUT_W(8), .ROUND_HALF(1'b1), .SATURATE(1'b1)) dut (
    .clk(clk), .srst(srst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample), .coef_num0(c_n0), .coef_num1(c_n1),
    .coef_den1(c_d1), .coef_den2(c_d2), .coef_direct(c_dir));

  pfb_parallel_iir #(.ORDER(5), .IN_W(8), .COEF_W(8), .STATE_W(12), .FRAC(6),
    .OUT_W(8), .ROUND_HALF(1'b0), .SATURATE(1'b0)) dut_trunc (
    .clk(clk), .srst(srst), .in_valid(in_valid), .in_ready(in_ready_t),
    .in_sample(in_sample), .out_valid(out_valid_t), .out_ready(out_ready),
    .out_sample(out_sample_t), .coef_num0(c_n0), .coef_num1(c_n1),
    .coef_den1(c_d1), .coef_den2(c_d2), .coef_direct(c_dir));

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int ma0 [NS], ma1 [NS], mb1 [NS], mb2 [NS];
  int mc;
  longint mw1 [NS], mw2 [NS];
  int q_rs [$];
  int q_tw [$];
  logic [15:0] lf = 16'hACE1;
  bit dense = 1'b1;
  bit hold_pend = 1'b0;
  int held = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // requirement-level arithmetic model (R2, R3, R4, R8, R9)
  task automatic model_step(input int x, output int yr, output int yt);
    longint sum, acc, w, y, r, t;
    sum = 0;
    for (int k = 0; k < NS; k++) begin
      bit fo = (k == NS - 1);
      acc = longint'(x) * 64 - longint'(mb1[k]) * mw1[k]
            - (fo ? 64'sd0 : longint'(mb2[k]) * mw2[k]);
      w = acc >>> 6;
      if (w > 2047) w = 2047;
      if (w < -2048) w = -2048;
      y = longint'(ma0[k]) * w + (fo ? 64'sd0 : longint'(ma1[k]) * mw1[k]);
      mw2[k] = mw1[k];
      mw1[k] = w;
      sum += y;
    end
    sum += longint'(mc) * x;
    r = (sum + 32) >>> 6;
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    yr = int'(r);
    t = (sum >>> 6) & 255;
    if (t >= 128) t -= 256;
    yt = int'(t);
  endtask

  task automatic set_coefs(input int s);
    for (int k = 0; k < NS; k++) begin
      if (s == 4) begin
        ma0[k] = 120; ma1[k] = 100; mb1[k] = -100; mb2[k] = 50;
      end else begin
        ma0[k] = 20 + 9*k - 13*s;
        ma1[k] = -15 + 11*s + 4*k;
        mb1[k] = -60 + 17*k + 23*s;
        mb2[k] = 25 + 6*k - 5*s;
      end
      c_n0[k*8 +: 8] = 8'(ma0[k]);
      c_n1[k*8 +: 8] = 8'(ma1[k]);
      c_d1[k*8 +: 8] = 8'(mb1[k]);
      c_d2[k*8 +: 8] = 8'(mb2[k]);
    end
    mc = (s == 4) ? 127 : 10 - 7*s;
    c_dir = 8'(mc);
  endtask

  task automatic do_reset();
    srst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    srst = 1'b0;
    for (int k = 0; k < NS; k++) begin mw1[k] = 0; mw2[k] = 0; end
    q_rs.delete(); q_tw.delete();
    hold_pend = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
  endtask

  // evaluate the handshakes that the next rising edge will see
  task automatic observe(input int x, output bit took);
    int er, et;
    took = 1'b0;
    #1;
    if (hold_pend) begin
      check(out_valid && (int'(out_sample) == held), "R6 output held under stall",
            int'(out_sample), held);
      hold_pend = 1'b0;
    end
    if (out_valid && !out_ready) begin
      check(!in_ready, "R6 in_ready low under stall", int'(in_ready), 0);
      hold_pend = 1'b1;
      held = int'(out_sample);
    end
    if (out_valid && out_ready) begin
      if (q_rs.size() == 0) begin
        check(1'b0, "R5 unexpected output", int'(out_sample), 0);
      end else begin
        er = q_rs.pop_front();
        et = q_tw.pop_front();
        check(int'(out_sample) == er, "R2,R3,R4,R7,R8,R9 rounded/saturated",
              int'(out_sample), er);
        check(int'(out_sample_t) == et, "R2,R3,R4,R7,R8,R9 floored/wrapped",
              int'(out_sample_t), et);
      end
    end
    if (in_valid && in_ready) begin
      model_step(x, er, et);
      q_rs.push_back(er);
      q_tw.push_back(et);
      took = 1'b1;
    end
  endtask

  task automatic send(input int x);
    bit took;
    took = 1'b0;
    while (!took) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      in_sample = 8'(x);
      in_valid  = dense ? 1'b1 : (lf[0] | lf[2]);
      out_ready = dense ? 1'b1 : (lf[4] | lf[7]);
      observe(x, took);
      @(negedge clk);
    end
  endtask

  task automatic drain();
    bit took;
    int guard = 0;
    in_valid = 1'b0;
    while ((q_rs.size() != 0) && (guard < 100)) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      out_ready = dense ? 1'b1 : (lf[4] | lf[7]);
      observe(0, took);
      @(negedge clk);
      guard++;
    end
    check(q_rs.size() == 0, "R5 all results delivered", q_rs.size(), 0);
  endtask

  initial begin
    int amps [5] = '{1, -1, 64, -128, 127};
    set_coefs(0);
    @(negedge clk);
    do_reset();

    // R5: two-edge latency with an empty pipeline
    in_sample = 8'sd5; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b0, "R5 not valid after first edge", int'(out_valid), 0);
    @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R5 valid after second edge", int'(out_valid), 1);

    for (int s = 0; s < 5; s++) begin
      set_coefs(s);
      @(negedge clk);
      do_reset();
      dense = (s % 2) == 0;
      foreach (amps[i]) begin
        send(amps[i]);
        repeat (20) send(0);
      end
      for (int v = -128; v < 128; v++) send(v);
      drain();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule